// File: doc/BRIEF.md
# Single-Wire Controller Reply Receiver

This block recovers the reply that a game controller sends back on a shared open-drain data wire after it has been polled. The controller times its reply from its own oscillator, so the wire is treated as asynchronous. The receiver passes it through a two-flop synchronizer. Every data symbol starts with a high-to-low transition. The receiver waits a fixed number of system cycles after each detected falling edge and then takes the wire level as the bit value.

The caller pulses `arm_i` with the expected symbol count on `nbits_i`. That count includes the trailing stop symbol. Data bits are shifted into `data_o` most-significant bit first and end up right-aligned. The stop symbol is consumed but not stored. When the stop symbol has been sampled, `valid_o` pulses for one cycle. If the next falling edge does not come within the watchdog window, `timeout_o` pulses for one cycle and the block goes idle, so the caller can poll again or reset the controller.

Top module: `swrx_receiver`

## Requirements
- R1: After reset, `data_o` is zero, `valid_o` and `timeout_o` are low, and the block is idle.
- R2: The wire passes through two synchronizing flops. A bit symbol begins at a high-to-low transition of the synchronized level.
- R3: The level is captured when SAMPLE_DLY cycles have elapsed after the falling edge was detected. A symbol whose low part is short (one quarter) reads as 1. A symbol whose low part is long (three quarters) reads as 0.
- R4: Data bits enter at bit 0 and move toward the MSB, so the first data bit received lands at bit position `nbits_i`-2. All bits above that position are zero.
- R5: `nbits_i` is latched when `arm_i` is sampled in idle and counts the stop symbol, which is not stored. An arm sampled in idle makes the block busy on the next cycle.
- R6: `valid_o` is a one-cycle pulse issued after the stop symbol is sampled. `data_o` keeps its value from that pulse until the next arm.
- R7: If no falling edge is detected for TIMEOUT_CYC cycles after the arm or after the last detected edge, `timeout_o` pulses for one cycle and the block returns to idle with no `valid_o`. When armed on a quiet wire, the pulse is high in the cycle after the TIMEOUT_CYC-th rising edge that follows the edge that sampled the arm.
- R8: An `arm_i` pulse that arrives while a reply is being received is ignored. Neither the count nor the data is disturbed.
- R9: `valid_o` and `timeout_o` are never high together. After either pulse the block stays idle until it is armed again.
- R10: After a timeout, a new arm receives a complete reply correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw asynchronous data wire level |
| arm_i | input | 1 | Start strobe, one cycle |
| nbits_i | input | $clog2(MAX_BITS+1) | Expected symbol count including stop |
| data_o | output | MAX_BITS-1 | Received data word, right-aligned |
| valid_o | output | 1 | One-cycle reply-complete pulse |
| timeout_o | output | 1 | One-cycle missing-edge pulse |

## Verification
Every symbol count from the minimum to the maximum is received with all-zero, all-one, single-MSB, single-LSB, alternating and counting patterns. These separate bit ordering, alignment and masking of the upper bits from errors in symbol decoding. A quiet wire after arming checks the exact watchdog latency. A reply that stops part-way checks the restart of the watchdog at each edge, and a following complete reply confirms recovery. An arm pulse in the middle of a reply, with a different count, shows that a busy block ignores re-arming.

// File: rtl/swrx_pkg.sv
package swrx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_HUNT   = 2'd1,
        RX_SETTLE = 2'd2
    } rx_state_e;

    // keep a requested symbol count within [2, maxb]
    function automatic int unsigned clamp_bits(int unsigned req, int unsigned maxb);
        if (req < 2)    return 2;
        if (req > maxb) return maxb;
        return req;
    endfunction

endpackage

// File: rtl/swrx_sync.sv
module swrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic fall_o
);
    // pipe[STAGES-1:0] synchronize, pipe[STAGES] holds the prior level
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-1:0], raw_i};
    end

    assign level_o = pipe[STAGES-1];
    assign fall_o  = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/swrx_shreg.sv
module swrx_shreg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          shift_i,
    input  logic          bit_i,
    output logic [DW-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) word_o <= '0;
        else if (shift_i) word_o <= {word_o[DW-2:0], bit_i};
    end
endmodule

// File: rtl/swrx_receiver.sv
module swrx_receiver
    import swrx_pkg::*;
#(
    parameter int MAX_BITS    = 33,
    parameter int SAMPLE_DLY  = 54,
    parameter int TIMEOUT_CYC = 216
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            line_i,
    input  logic                            arm_i,
    input  logic [$clog2(MAX_BITS+1)-1:0]   nbits_i,
    output logic [MAX_BITS-2:0]             data_o,
    output logic                            valid_o,
    output logic                            timeout_o
);
    localparam int DW   = MAX_BITS - 1;
    localparam int NW   = $clog2(MAX_BITS + 1);
    localparam int DLYW = $clog2(SAMPLE_DLY + 1);
    localparam int TOW  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [DLYW-1:0] DLY_LAST = DLYW'(SAMPLE_DLY - 1);
    localparam logic [TOW-1:0]  TO_LAST  = TOW'(TIMEOUT_CYC - 1);

    rx_state_e       st;
    logic [NW-1:0]   need, got;
    logic [DLYW-1:0] dly;
    logic [TOW-1:0]  wdog;
    logic            level, fall;
    logic            busy, start, sample_now, last_sym;

    swrx_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (line_i),
        .level_o (level),
        .fall_o  (fall)
    );

    assign busy       = (st != RX_IDLE);
    assign start      = (st == RX_IDLE) && arm_i;
    assign sample_now = (st == RX_SETTLE) && (dly == DLY_LAST);
    assign last_sym   = (got == need - 1'b1);

    swrx_shreg #(.DW(DW)) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (start),
        .shift_i (sample_now && !last_sym),
        .bit_i   (level),
        .word_o  (data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            need      <= '0;
            got       <= '0;
            dly       <= '0;
            wdog      <= '0;
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    if (arm_i) begin
                        st   <= RX_HUNT;
                        need <= NW'(clamp_bits(32'(nbits_i), MAX_BITS));
                        got  <= '0;
                        wdog <= '0;
                    end
                end
                RX_HUNT: begin
                    if (fall) begin
                        st   <= RX_SETTLE;
                        dly  <= '0;
                        wdog <= '0;
                    end else if (wdog == TO_LAST) begin
                        timeout_o <= 1'b1;
                        st        <= RX_IDLE;
                    end else begin
                        wdog <= wdog + 1'b1;
                    end
                end
                RX_SETTLE: begin
                    wdog <= wdog + 1'b1;
                    if (sample_now) begin
                        if (last_sym) begin
                            valid_o <= 1'b1;
                            st      <= RX_IDLE;
                        end else begin
                            got <= got + 1'b1;
                            st  <= RX_HUNT;
                        end
                    end else begin
                        dly <= dly + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swrx_checker.sv
module swrx_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          arm,
    input logic          busy,
    input logic          valid,
    input logic          timeout,
    input logic [DW-1:0] data
);
    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(valid && timeout));

    assert_vpulse_R6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        valid |=> $stable(data));

    assert_tpulse_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    assert_idle_after_R9: assert property (@(posedge clk) disable iff (rst)
        (valid || timeout) |-> !busy);

    assert_arm_start_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && arm) |=> busy);
endmodule

bind swrx_receiver swrx_checker #(.DW(MAX_BITS - 1)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm_i),
    .busy    (busy),
    .valid   (valid_o),
    .timeout (timeout_o),
    .data    (data_o)
);

// File: tb/tb_swrx_receiver.sv
`timescale 1ns/1ps
module tb_swrx_receiver;
    localparam int MAXB = 9;
    localparam int DLY  = 6;
    localparam int TO   = 20;
    localparam int SUB  = 3;   // cycles per quarter symbol

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line = 1'b1;
    logic       arm = 1'b0;
    logic [3:0] nb = '0;
    logic [7:0] data_o;
    logic       valid_o, timeout_o;

    int nvalid = 0, ntout = 0, total = 0, fails = 0;
    logic [7:0] vdata = '0;
    bit done = 0;

    always #2 clk = ~clk;

    swrx_receiver #(.MAX_BITS(MAXB), .SAMPLE_DLY(DLY), .TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst(rst), .line_i(line), .arm_i(arm), .nbits_i(nb),
        .data_o(data_o), .valid_o(valid_o), .timeout_o(timeout_o)
    );

    always @(negedge clk) begin
        if (!rst && valid_o) begin nvalid++; vdata = data_o; end
        if (!rst && timeout_o) ntout++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    task automatic do_arm(input int n);
        arm = 1'b1; nb = 4'(n);
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        line = 1'b0;
        repeat (b ? SUB : 3*SUB) @(negedge clk);
        line = 1'b1;
        repeat (b ? 3*SUB : SUB) @(negedge clk);
    endtask

    task automatic run_rx(input int n, input logic [7:0] v);
        int v0, t0;
        logic [7:0] exp;
        v0 = nvalid; t0 = ntout;
        exp = v & 8'((1 << (n-1)) - 1);
        do_arm(n);
        repeat (2) @(negedge clk);
        for (int i = n-2; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b1);
        repeat (10) @(negedge clk);
        chk(nvalid == v0 + 1, "R5 R6 valid count", nvalid - v0, 1);
        chk(vdata == exp, "R2 R3 R4 data", vdata, exp);
        chk(data_o == exp, "R6 hold", data_o, exp);
        chk(ntout == t0, "R9 no timeout", ntout - t0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(data_o == 0, "R1 data", data_o, 0);
        chk(valid_o == 0, "R1 valid", valid_o, 0);
        chk(timeout_o == 0, "R1 timeout", timeout_o, 0);

        // sweep of counts and patterns (R2 R3 R4 R5 R6)
        for (int n = 2; n <= MAXB; n++) begin
            run_rx(n, 8'h00);
            run_rx(n, 8'hFF);
            run_rx(n, 8'(1 << (n-2)));
            run_rx(n, 8'h01);
            run_rx(n, 8'hA5);
            run_rx(n, 8'(n*37 + 11));
        end

        // R7 exact latency on a quiet wire
        begin
            int k, t0, v0;
            t0 = ntout; v0 = nvalid; k = 0;
            arm = 1'b1; nb = 4'd9;
            @(negedge clk);
            arm = 1'b0; k = 1;
            while (!timeout_o && k < 3*TO) begin
                @(negedge clk); k++;
            end
            chk(k == TO + 1, "R7 latency", k, TO + 1);
            repeat (30) @(negedge clk);
            chk(ntout == t0 + 1, "R7 single pulse", ntout - t0, 1);
            chk(nvalid == v0, "R7 no valid", nvalid - v0, 0);
        end

        // R10 recovery
        run_rx(9, 8'h3C);

        // R7 reply stopping after two bits
        begin
            int t0, v0;
            t0 = ntout; v0 = nvalid;
            do_arm(5);
            repeat (2) @(negedge clk);
            send_bit(1'b1);
            send_bit(1'b0);
            repeat (3*TO) @(negedge clk);
            chk(ntout == t0 + 1, "R7 partial timeout", ntout - t0, 1);
            chk(nvalid == v0, "R7 partial no valid", nvalid - v0, 0);
        end

        run_rx(6, 8'h15);   // R10 again after partial timeout

        // R8 arm during reception with a different count
        begin
            int v0, t0;
            v0 = nvalid; t0 = ntout;
            do_arm(5);
            repeat (2) @(negedge clk);
            send_bit(1'b1);
            send_bit(1'b0);
            arm = 1'b1; nb = 4'd9;
            @(negedge clk);
            arm = 1'b0;
            line = 1'b1;
            repeat (2) @(negedge clk);
            send_bit(1'b1);
            send_bit(1'b1);
            send_bit(1'b1);   // stop
            repeat (10) @(negedge clk);
            chk(nvalid == v0 + 1, "R8 valid", nvalid - v0, 1);
            chk(vdata == 8'h0B, "R8 data", vdata, 8'h0B);
            chk(ntout == t0, "R8 no timeout", ntout - t0, 0);
            repeat (3*TO) @(negedge clk);
            chk(ntout == t0, "R9 stays idle", ntout - t0, 0);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule